// File: doc/BRIEF.md
# Power-On Startup Sequencer

This block drives the start-up of a device that needs no configuration load. Once its supply-good input rises, it steps through a fixed series of phases: a power-on hold, a short initialization step, an added-delay phase, and a start-up phase. It then enters user mode. Along the way it produces the open-drain style control lines a board expects from such a part. These are an active-low status line, a configuration-done release, an init-done flag, an active-low chain-enable output for the next device, a tri-state enable for the user I/O, and a weak pull-up enable.

Every interval is a parameter counted in clock cycles. The defaults are derived from a clock-frequency parameter, so that the long intervals can be shortened for simulation. The length of the added delay is chosen at build time: a short one of about 70 µs, or a long one of about 50 ms. A low restart request sends the sequencer back to the power-on phase from any point in the sequence. Dropping supply-good resets it asynchronously.

Top module: `boot_phase_seq`

## Requirements
- R1: The phase output takes the codes 0 (power-on hold), 1 (initialization), 2 (added delay), 3 (start-up) and 4 (user mode). Apart from a return to 0, it only moves forward 0→1→2→3→4, one step at a time.
- R2: After pwr_good rises with restart_n high, status_n stays low for exactly POR_FAST_CYC cycles when por_sel is 1, or POR_SLOW_CYC cycles when por_sel is 0. It then goes high as phase 1 begins.
- R3: Phase 2 lasts SHORT_ADD_CYC cycles when LONG_DELAY is 0 and LONG_ADD_CYC cycles when LONG_DELAY is 1.
- R4: While restart_n is held low, the sequencer stays in phase 0 even after the hold time has expired. After restart_n rises, phase 1 begins on the third rising clock edge.
- R5: When restart_n falls while the sequencer is outside phase 0, status_n goes low on the third rising edge after the fall. Once restart_n returns high, phase 1 begins on the third edge, and the hold time is not counted again.
- R6: cfg_done rises DONE_LAG_CYC cycles after phase 3 begins. init_done rises USER_LAG_CYC cycles after cfg_done, as phase 4 begins. Both return low on any restart.
- R7: io_hiz is high in every phase except 4. weak_pu_en is high in phases 0 and 1 only while pullup_off is low.
- R8: chain_out_n is low exactly when cfg_done is high.
- R9: Phase 1 does not advance while chain_en_n is high. It advances to phase 2 on the first edge with chain_en_n low.
- R10: pwr_good low at once forces phase 0 and the outputs status_n=0, cfg_done=0, init_done=0, chain_out_n=1 and io_hiz=1, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| pwr_good | input | 1 | Supply good; low acts as asynchronous reset |
| restart_n | input | 1 | Active-low restart request, asynchronous |
| por_sel | input | 1 | Hold-time select: 1 short, 0 long |
| chain_en_n | input | 1 | Active-low enable from the previous device in a chain |
| pullup_off | input | 1 | High disables weak pull-ups during phases 0 and 1 |
| status_n | output | 1 | Active-low status, low during phase 0 |
| cfg_done | output | 1 | Configuration-done release |
| init_done | output | 1 | High in user mode |
| chain_out_n | output | 1 | Active-low enable to the next device in a chain |
| io_hiz | output | 1 | High keeps user I/O tri-stated |
| weak_pu_en | output | 1 | Weak pull-up enable for user I/O |
| phase_code | output | 3 | Current phase code |

## Verification
Two copies are built, one with each delay mode, and they are driven by the same stimulus. This lets a single run separate the short added delay from the long one. The stimulus covers these cases, each of which separates two behaviours:
- A clean power-up with each hold-time select separates the two hold lengths.
- A restart pulse in user mode and another in the middle of the long delay check that a restart returns to phase 0 without counting the hold time again.
- A restart held low through the whole hold separates "hold expired" from "allowed to proceed".
- chain_en_n held high in phase 1 shows that the gate stalls the sequence rather than skipping it.
- Toggling pullup_off across a restart separates the pull-up enable from the phase it depends on.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

    typedef enum logic [2:0] {
        PH_PWRUP = 3'd0,
        PH_INIT  = 3'd1,
        PH_DELAY = 3'd2,
        PH_START = 3'd3,
        PH_USER  = 3'd4
    } boot_phase_e;

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/boot_sync2.sv
module boot_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = d;
        sy_d.s2 = sy_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign q = sy_q.s2;
endmodule

// File: rtl/boot_limits.sv
module boot_limits #(
    parameter int CNT_W         = 8,
    parameter int POR_FAST_CYC  = 20,
    parameter int POR_SLOW_CYC  = 40,
    parameter int SHORT_ADD_CYC = 6,
    parameter int LONG_ADD_CYC  = 30,
    parameter bit LONG_DELAY    = 1'b0
) (
    input  logic             por_sel,
    output logic [CNT_W-1:0] por_lim,
    output logic [CNT_W-1:0] add_lim
);
    assign por_lim = por_sel ? CNT_W'(POR_FAST_CYC) : CNT_W'(POR_SLOW_CYC);

    generate
        if (LONG_DELAY) begin : g_long
            assign add_lim = CNT_W'(LONG_ADD_CYC);
        end else begin : g_short
            assign add_lim = CNT_W'(SHORT_ADD_CYC);
        end
    endgenerate
endmodule

// File: rtl/boot_fsm_core.sv
module boot_fsm_core
    import boot_seq_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int DONE_LAG_CYC = 3,
    parameter int USER_LAG_CYC = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_s,
    input  logic             chain_en_n,
    input  logic [CNT_W-1:0] por_lim,
    input  logic [CNT_W-1:0] add_lim,
    output boot_phase_e      phase,
    output logic             cfg_rel
);
    localparam logic [CNT_W-1:0] DONE_LAST = CNT_W'(DONE_LAG_CYC - 1);
    localparam logic [CNT_W-1:0] USER_LAST = CNT_W'(USER_LAG_CYC - 1);

    typedef struct packed {
        boot_phase_e      phase;
        logic [CNT_W-1:0] cnt;
        logic             por_met;
        logic             rel;
    } seq_t;

    seq_t st_d, st_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             por_hit;

    always_comb begin
        st_d    = st_q;
        cnt_inc = st_q.cnt + CNT_W'(1);
        por_hit = 1'b0;
        case (st_q.phase)
            PH_PWRUP: begin
                por_hit = st_q.por_met || (st_q.cnt == por_lim - CNT_W'(1));
                if (!st_q.por_met) st_d.cnt = cnt_inc;
                if (por_hit)       st_d.por_met = 1'b1;
                if (por_hit && restart_s) begin
                    st_d.phase = PH_INIT;
                    st_d.cnt   = '0;
                end
            end
            PH_INIT: begin
                if (!chain_en_n) begin
                    st_d.phase = PH_DELAY;
                    st_d.cnt   = '0;
                end
            end
            PH_DELAY: begin
                if (st_q.cnt == add_lim - CNT_W'(1)) begin
                    st_d.phase = PH_START;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
            PH_START: begin
                if (!st_q.rel) begin
                    if (st_q.cnt == DONE_LAST) begin
                        st_d.rel = 1'b1;
                        st_d.cnt = '0;
                    end else begin
                        st_d.cnt = cnt_inc;
                    end
                end else if (st_q.cnt == USER_LAST) begin
                    st_d.phase = PH_USER;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = cnt_inc;
                end
            end
            PH_USER: ;
            default: begin
                st_d.phase = PH_PWRUP;
                st_d.cnt   = '0;
                st_d.rel   = 1'b0;
            end
        endcase
        if (!restart_s && st_q.phase != PH_PWRUP) begin
            st_d.phase = PH_PWRUP;
            st_d.cnt   = '0;
            st_d.rel   = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase   <= PH_PWRUP;
            st_q.cnt     <= '0;
            st_q.por_met <= 1'b0;
            st_q.rel     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase   = st_q.phase;
    assign cfg_rel = st_q.rel;

    // R5: a synchronized restart request lands in phase 0 on the next edge
    a_r5_restart_to_pwrup: assert property (@(posedge clk) disable iff (!rst_n)
        !restart_s |=> st_q.phase == PH_PWRUP);

    // R1: each forward phase is only entered from its predecessor
    a_r1_delay_after_init: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_DELAY && $past(st_q.phase) != PH_DELAY) |-> $past(st_q.phase) == PH_INIT);
    a_r1_start_after_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_START && $past(st_q.phase) != PH_START) |-> $past(st_q.phase) == PH_DELAY);
    a_r1_user_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_USER && $past(st_q.phase) != PH_USER) |-> $past(st_q.phase) == PH_START);

    // R9: initialization waits for the chain enable
    a_r9_init_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_INIT && chain_en_n) |=> st_q.phase != PH_DELAY);

    // R6: the release only appears during start-up
    a_r6_rel_in_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.rel) |-> st_q.phase == PH_START);
endmodule

// File: rtl/boot_phase_seq.sv
module boot_phase_seq
    import boot_seq_pkg::*;
#(
    parameter int CLK_HZ        = 50_000_000,
    parameter int POR_FAST_CYC  = CLK_HZ / 1000 * 12,
    parameter int POR_SLOW_CYC  = CLK_HZ / 10,
    parameter int SHORT_ADD_CYC = CLK_HZ / 1_000_000 * 70,
    parameter int LONG_ADD_CYC  = CLK_HZ / 20,
    parameter int DONE_LAG_CYC  = CLK_HZ / 1_000_000,
    parameter int USER_LAG_CYC  = CLK_HZ / 1_000_000 * 80,
    parameter bit LONG_DELAY    = 1'b0
) (
    input  logic       clk,
    input  logic       pwr_good,
    input  logic       restart_n,
    input  logic       por_sel,
    input  logic       chain_en_n,
    input  logic       pullup_off,
    output logic       status_n,
    output logic       cfg_done,
    output logic       init_done,
    output logic       chain_out_n,
    output logic       io_hiz,
    output logic       weak_pu_en,
    output logic [2:0] phase_code
);
    localparam int LIM_MAX = imax(imax(imax(POR_FAST_CYC, POR_SLOW_CYC),
                                       imax(SHORT_ADD_CYC, LONG_ADD_CYC)),
                                  imax(DONE_LAG_CYC, USER_LAG_CYC));
    localparam int CNT_W = $clog2(LIM_MAX + 1);

    logic             restart_s;
    logic [CNT_W-1:0] por_lim;
    logic [CNT_W-1:0] add_lim;
    boot_phase_e      phase;
    logic             cfg_rel;

    boot_sync2 u_sync (
        .clk   (clk),
        .rst_n (pwr_good),
        .d     (restart_n),
        .q     (restart_s)
    );

    boot_limits #(
        .CNT_W         (CNT_W),
        .POR_FAST_CYC  (POR_FAST_CYC),
        .POR_SLOW_CYC  (POR_SLOW_CYC),
        .SHORT_ADD_CYC (SHORT_ADD_CYC),
        .LONG_ADD_CYC  (LONG_ADD_CYC),
        .LONG_DELAY    (LONG_DELAY)
    ) u_lim (
        .por_sel (por_sel),
        .por_lim (por_lim),
        .add_lim (add_lim)
    );

    boot_fsm_core #(
        .CNT_W        (CNT_W),
        .DONE_LAG_CYC (DONE_LAG_CYC),
        .USER_LAG_CYC (USER_LAG_CYC)
    ) u_core (
        .clk        (clk),
        .rst_n      (pwr_good),
        .restart_s  (restart_s),
        .chain_en_n (chain_en_n),
        .por_lim    (por_lim),
        .add_lim    (add_lim),
        .phase      (phase),
        .cfg_rel    (cfg_rel)
    );

    always_comb begin
        status_n    = (phase != PH_PWRUP);
        cfg_done    = cfg_rel;
        chain_out_n = !cfg_rel;
        init_done   = (phase == PH_USER);
        io_hiz      = (phase != PH_USER);
        weak_pu_en  = ((phase == PH_PWRUP) || (phase == PH_INIT)) && !pullup_off;
        phase_code  = phase;
    end

    // R6: user mode never precedes the configuration-done release
    a_r6_init_after_done: assert property (@(posedge clk) disable iff (!pwr_good)
        init_done |-> cfg_done);

    // R7: pull-ups are only enabled while the I/O is still tri-stated
    a_r7_pullup_hiz: assert property (@(posedge clk) disable iff (!pwr_good)
        weak_pu_en |-> io_hiz);

    // R2: the status line is low whenever the sequencer sits in phase 0
    a_r2_status_por: assert property (@(posedge clk) disable iff (!pwr_good)
        (phase_code == 3'd0) |-> !status_n);
endmodule

// File: tb/boot_phase_seq_tb.sv
module boot_phase_seq_tb_top;
    localparam int P_FAST  = 20;
    localparam int P_SLOW  = 45;
    localparam int P_SHORT = 6;
    localparam int P_LONG  = 30;
    localparam int P_DONE  = 3;
    localparam int P_USER  = 7;

    logic clk = 1'b0;
    logic pwr_good = 1'b0, restart_n = 1'b1, por_sel = 1'b1;
    logic chain_en_n = 1'b0, pullup_off = 1'b0;

    logic st0, cd0, id0, co0, hz0, pu0; logic [2:0] ph0;
    logic st1, cd1, id1, co1, hz1, pu1; logic [2:0] ph1;

    int checks = 0, failures = 0;

    always #10 clk = ~clk;

    boot_phase_seq #(.POR_FAST_CYC(P_FAST), .POR_SLOW_CYC(P_SLOW), .SHORT_ADD_CYC(P_SHORT),
        .LONG_ADD_CYC(P_LONG), .DONE_LAG_CYC(P_DONE), .USER_LAG_CYC(P_USER), .LONG_DELAY(1'b0)) dut_i (
        .clk(clk), .pwr_good(pwr_good), .restart_n(restart_n), .por_sel(por_sel),
        .chain_en_n(chain_en_n), .pullup_off(pullup_off), .status_n(st0), .cfg_done(cd0),
        .init_done(id0), .chain_out_n(co0), .io_hiz(hz0), .weak_pu_en(pu0), .phase_code(ph0));

    boot_phase_seq #(.POR_FAST_CYC(P_FAST), .POR_SLOW_CYC(P_SLOW), .SHORT_ADD_CYC(P_SHORT),
        .LONG_ADD_CYC(P_LONG), .DONE_LAG_CYC(P_DONE), .USER_LAG_CYC(P_USER), .LONG_DELAY(1'b1)) dut_long_i (
        .clk(clk), .pwr_good(pwr_good), .restart_n(restart_n), .por_sel(por_sel),
        .chain_en_n(chain_en_n), .pullup_off(pullup_off), .status_n(st1), .cfg_done(cd1),
        .init_done(id1), .chain_out_n(co1), .io_hiz(hz1), .weak_pu_en(pu1), .phase_code(ph1));

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: per-instance phase, cycles left, hold-left, release flag.
    int m_ph[2], m_left[2], m_por[2];
    bit m_rel[2];
    bit sync_q[$];
    bit rs;

    task automatic step(int i, bit r);
        if (!r && m_ph[i] != 0) begin
            m_ph[i] = 0; m_rel[i] = 1'b0;
            return;
        end
        case (m_ph[i])
            0: begin
                if (m_por[i] > 0) m_por[i]--;
                if (m_por[i] == 0 && r) m_ph[i] = 1;
            end
            1: if (!chain_en_n) begin
                m_ph[i] = 2; m_left[i] = (i == 0) ? P_SHORT : P_LONG;
            end
            2: begin
                m_left[i]--;
                if (m_left[i] == 0) begin m_ph[i] = 3; m_left[i] = P_DONE; end
            end
            3: begin
                m_left[i]--;
                if (m_left[i] == 0) begin
                    if (!m_rel[i]) begin m_rel[i] = 1'b1; m_left[i] = P_USER; end
                    else m_ph[i] = 4;
                end
            end
            default: ;
        endcase
    endtask

    always @(posedge clk or negedge pwr_good) begin
        if (!pwr_good) begin
            sync_q = '{1'b0, 1'b0};
            for (int i = 0; i < 2; i++) begin
                m_ph[i] = 0; m_rel[i] = 1'b0; m_left[i] = 0;
                m_por[i] = por_sel ? P_FAST : P_SLOW;
            end
        end else begin
            rs = sync_q.pop_front();
            sync_q.push_back(restart_n);
            for (int i = 0; i < 2; i++) step(i, rs);
        end
    end

    task automatic compare_one(int i, logic [2:0] ph, logic st, logic cd, logic id,
                               logic co, logic hz, logic pu);
        bit e_pu;
        e_pu = (m_ph[i] <= 1) && !pullup_off;
        chk(ph == m_ph[i][2:0], $sformatf("R1 phase inst%0d", i), ph, m_ph[i]);
        chk(st == (m_ph[i] != 0), $sformatf("R2 status_n inst%0d", i), st, m_ph[i] != 0);
        chk(cd == m_rel[i], $sformatf("R6 cfg_done inst%0d", i), cd, m_rel[i]);
        chk(id == (m_ph[i] == 4), $sformatf("R6 init_done inst%0d", i), id, m_ph[i] == 4);
        chk(hz == (m_ph[i] != 4), $sformatf("R7 io_hiz inst%0d", i), hz, m_ph[i] != 4);
        chk(pu == e_pu, $sformatf("R7 weak_pu_en inst%0d", i), pu, e_pu);
        chk(co == !m_rel[i], $sformatf("R8 chain_out_n inst%0d", i), co, !m_rel[i]);
    endtask

    int run_len[2] = '{0, 0};
    int dly_len[2] = '{0, 0};

    always @(posedge clk) begin
        #5;
        compare_one(0, ph0, st0, cd0, id0, co0, hz0, pu0);
        compare_one(1, ph1, st1, cd1, id1, co1, hz1, pu1);
        if (ph0 == 3'd2) run_len[0]++;
        else if (run_len[0] != 0) begin dly_len[0] = run_len[0]; run_len[0] = 0; end
        if (ph1 == 3'd2) run_len[1]++;
        else if (run_len[1] != 0) begin dly_len[1] = run_len[1]; run_len[1] = 0; end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        tick(3);
        // R10: reset state
        chk(st0 == 0 && cd0 == 0 && id0 == 0 && co0 == 1 && hz0 == 1 && ph0 == 0,
            "R10 reset outputs", {st0, cd0, id0, co0, hz0}, 5'b00011);
        pwr_good = 1'b1;
        tick(P_FAST - 1);
        chk(st0 == 0, "R2 hold fast, still low", st0, 0);
        tick(1);
        chk(st0 == 1 && ph0 == 3'd1, "R2 hold fast, released", ph0, 1);
        tick(60);
        chk(id0 == 1 && id1 == 1, "R6 both in user mode", {id0, id1}, 3);
        chk(dly_len[0] == P_SHORT, "R3 short delay length", dly_len[0], P_SHORT);
        chk(dly_len[1] == P_LONG, "R3 long delay length", dly_len[1], P_LONG);

        // R5: restart pulse from user mode
        restart_n = 1'b0;
        tick(2);
        chk(st0 == 1, "R5 status before sync latency", st0, 1);
        tick(1);
        chk(st0 == 0, "R5 status low on third edge", st0, 0);
        tick(3);
        pullup_off = 1'b1;
        restart_n  = 1'b1;
        tick(2);
        chk(st0 == 0, "R5 still in phase 0", st0, 0);
        tick(1);
        chk(ph0 == 3'd1 && ph1 == 3'd1, "R5 hold not repeated", ph0, 1);
        tick(50);
        pullup_off = 1'b0;

        // R5: restart in the middle of the long delay
        restart_n = 1'b0; tick(4); restart_n = 1'b1; tick(13);
        chk(ph1 == 3'd2, "R5 long instance mid-delay", ph1, 2);
        restart_n = 1'b0; tick(5); restart_n = 1'b1; tick(60);
        chk(id1 == 1, "R5 long instance recovers", id1, 1);

        // R9: chain enable gate
        chain_en_n = 1'b1;
        restart_n = 1'b0; tick(4); restart_n = 1'b1; tick(13);
        chk(ph0 == 3'd1 && ph1 == 3'd1, "R9 held in phase 1", ph0, 1);
        chain_en_n = 1'b0;
        tick(1);
        chk(ph0 == 3'd2 && ph1 == 3'd2, "R9 advances after enable", ph0, 2);
        tick(60);

        // R2: slow hold time
        pwr_good = 1'b0; por_sel = 1'b0; tick(2);
        pwr_good = 1'b1;
        tick(P_SLOW - 1);
        chk(st0 == 0, "R2 hold slow, still low", st0, 0);
        tick(1);
        chk(st0 == 1, "R2 hold slow, released", st0, 1);
        tick(60);

        // R4: restart held low across the whole hold
        pwr_good = 1'b0; restart_n = 1'b0; tick(2);
        pwr_good = 1'b1;
        tick(P_SLOW + 15);
        chk(ph0 == 3'd0 && st0 == 0, "R4 held in phase 0", ph0, 0);
        restart_n = 1'b1;
        tick(2);
        chk(ph0 == 3'd0, "R4 before sync latency", ph0, 0);
        tick(1);
        chk(ph0 == 3'd1, "R4 proceeds after release", ph0, 1);
        tick(60);

        // R10: asynchronous drop of supply-good in user mode
        pwr_good = 1'b0; por_sel = 1'b1; tick(2);
        pwr_good = 1'b1;
        tick(40);
        chk(id0 == 1, "R10 in user mode before drop", id0, 1);
        pwr_good = 1'b0;
        #1;
        chk(st0 == 0 && cd0 == 0 && id0 == 0 && co0 == 1 && hz0 == 1 && ph0 == 0,
            "R10 async reset outputs", {st0, cd0, id0, co0, hz0}, 5'b00011);
        tick(2);
        finish_run();
    end
endmodule